// File: doc/BRIEF.md
# Peak-Hold Level Flag Encoder

This block sits beside one audio channel and watches its signed sample stream. It turns the magnitude of every accepted sample into a level band on a coarse, non-uniform dB scale. It keeps the loudest band seen since the last clear as a 3-bit code. A microcontroller reads that code through a status register. The read strobe clears the held code, so each read reports the peak since the previous read.

The sample input uses a valid/ready pair. The block never applies back-pressure: `smp_ready` is always high, and a sample is taken on every clock edge where `smp_valid` is high. The other pins are plain levels or strobes. `pd_n` is an asynchronous active-low power-down reset. `pm_en` is the channel power-management enable: while it is low, the block holds the code at 000 and ignores samples.

Top module: `peak_level_flag`

## Requirements
- R1: While `pd_n` is low, `level_code` is 000, including a power-down asserted in the middle of operation; after release it stays 000 until a sample is accepted.
- R2: An accepted sample is classified by its magnitude m, with W=16, into these codes: 000 below 8192; 001 at m ≥ 8192 (1/4 FS, -12.04 dB); 010 at m ≥ 12288 (3/8 FS, -8.52 dB); 011 at m ≥ 16384 (1/2 FS, -6.02 dB); 100 at m ≥ 20480 (5/8 FS, -4.08 dB); 101 at m ≥ 26624 (13/16 FS, -1.80 dB); 110 at m ≥ 32767 (clipping, 0 dB).
- R3: The magnitude of a negative sample is its absolute value. The most negative value (-32768) saturates to 32767 and therefore reports 110.
- R4: Between clears, the held code is the maximum of the codes of the accepted samples. A sample with a lower code leaves the held code unchanged.
- R5: A read strobe with no accepted sample clears `level_code` to 000 on the next clock edge.
- R6: A read strobe and an accepted sample in the same cycle load that sample's code rather than 000.
- R7: While `pm_en` is 0, `level_code` is 000 on the next edge and samples have no effect.
- R8: Code 111 never appears on `level_code`.
- R9: `smp_ready` is always 1, and data presented with `smp_valid` low has no effect on `level_code`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| pd_n | input | 1 | Asynchronous power-down reset, active low |
| pm_en | input | 1 | Channel power-management enable; 0 clears and blocks updates |
| smp_valid | input | 1 | Sample valid |
| smp_ready | output | 1 | Sample ready, constantly 1 |
| smp_data | input | 16 | Signed two's-complement sample (parameter W) |
| rd_strobe | input | 1 | One-cycle status read; clears the held code |
| level_code | output | 3 | Held peak level code |

## Verification
The case hardest to reach from the ports is a read that falls in the same cycle as a sample. That sample's code must survive the clear, and the outcome is only visible once the held value is already higher than the new sample. The stimulus reaches this case in two ways. Directed steps pair reads with samples sitting exactly on each band edge and one below it. A seeded random phase biases samples toward the band edges and fires reads at random, so reads often coincide with samples while a larger peak is held. The saturating magnitude at the most negative input is also driven directly.

// File: rtl/plvl_pkg.sv
package plvl_pkg;
  typedef logic [2:0] lvl_code_t;
  localparam int NUM_EDGES = 6;

  // Lower magnitude bound of band k+1, as a fraction of full scale 2^(w-1).
  function automatic longint band_floor(input int k, input int w);
    longint fs;
    fs = longint'(1) << (w - 1);
    case (k)
      0:       return fs / 4;
      1:       return (3 * fs) / 8;
      2:       return fs / 2;
      3:       return (5 * fs) / 8;
      4:       return (13 * fs) / 16;
      default: return fs - 1;
    endcase
  endfunction
endpackage

// File: rtl/plvl_abs_sat.sv
module plvl_abs_sat #(
  parameter int W = 16,
  localparam int MAGW = W - 1
) (
  input  logic [W-1:0]    din,
  output logic [MAGW-1:0] mag
);
  localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};
  logic [W-1:0] negated;

  always_comb begin
    negated = ~din + 1'b1;
    if (!din[W-1])          mag = din[MAGW-1:0];
    else if (din == MOST_NEG) mag = '1;
    else                    mag = negated[MAGW-1:0];
  end

  always_comb begin
    // R3
    if (din == MOST_NEG) begin
      most_neg_sat_chk: assert (mag == {MAGW{1'b1}});
    end
  end
endmodule

// File: rtl/plvl_classify.sv
module plvl_classify
  import plvl_pkg::*;
#(
  parameter int W = 16,
  localparam int MAGW = W - 1
) (
  input  logic [MAGW-1:0] mag,
  output lvl_code_t       code
);
  logic [NUM_EDGES-1:0] above;

  for (genvar k = 0; k < NUM_EDGES; k++) begin : g_edge
    localparam logic [MAGW-1:0] FLOOR = MAGW'(band_floor(k, W));
    assign above[k] = (mag >= FLOOR);
  end

  assign code = lvl_code_t'($countones(above));

  always_comb begin
    // R2
    therm_shape_chk: assert ((above & (above + 1'b1)) == '0);
    // R8
    code_range_chk: assert (code != 3'b111);
  end
endmodule

// File: rtl/plvl_hold.sv
module plvl_hold
  import plvl_pkg::*;
(
  input  logic      clk,
  input  logic      pd_n,
  input  logic      pm_en,
  input  logic      load,
  input  logic      rd,
  input  lvl_code_t new_code,
  output lvl_code_t held
);
  lvl_code_t held_nx;

  always_comb begin
    held_nx = held;
    if (!pm_en)    held_nx = '0;
    else if (load) held_nx = (rd || new_code > held) ? new_code : held;
    else if (rd)   held_nx = '0;
  end

  always_ff @(posedge clk or negedge pd_n) begin
    if (!pd_n) held <= '0;
    else       held <= held_nx;
  end

  // R4
  no_decrease_chk: assert property (@(posedge clk) disable iff (!pd_n)
    (pm_en && !rd) |=> (held >= $past(held)));
  // R5
  read_clear_chk: assert property (@(posedge clk) disable iff (!pd_n)
    (pm_en && rd && !load) |=> (held == '0));
  // R6
  read_load_chk: assert property (@(posedge clk) disable iff (!pd_n)
    (pm_en && rd && load) |=> (held == $past(new_code)));
  // R7
  pm_off_chk: assert property (@(posedge clk) disable iff (!pd_n)
    !pm_en |=> (held == '0));
  // R9
  idle_stable_chk: assert property (@(posedge clk) disable iff (!pd_n)
    (pm_en && !load && !rd) |=> $stable(held));
endmodule

// File: rtl/peak_level_flag.sv
module peak_level_flag
  import plvl_pkg::*;
#(
  parameter int W = 16,
  localparam int MAGW = W - 1
) (
  input  logic         clk,
  input  logic         pd_n,
  input  logic         pm_en,
  input  logic         smp_valid,
  output logic         smp_ready,
  input  logic [W-1:0] smp_data,
  input  logic         rd_strobe,
  output logic [2:0]   level_code
);
  logic [MAGW-1:0] mag;
  lvl_code_t       smp_code;
  lvl_code_t       held;

  assign smp_ready = 1'b1;

  plvl_abs_sat #(.W(W)) u_abs (.din(smp_data), .mag(mag));

  plvl_classify #(.W(W)) u_cls (.mag(mag), .code(smp_code));

  plvl_hold u_hold (
    .clk(clk), .pd_n(pd_n), .pm_en(pm_en),
    .load(smp_valid && smp_ready), .rd(rd_strobe),
    .new_code(smp_code), .held(held)
  );

  assign level_code = held;

  // R1
  pd_clear_chk: assert property (@(posedge clk) !pd_n |-> (level_code == 3'b000));
endmodule

// File: tb/test_peak_level_flag.sv
module test_peak_level_flag;
  logic        clk = 1'b0;
  logic        pd_n = 1'b0;
  logic        pm_en = 1'b1;
  logic        smp_valid = 1'b0;
  logic        smp_ready;
  logic [15:0] smp_data = '0;
  logic        rd_strobe = 1'b0;
  logic [2:0]  level_code;

  int checks = 0;
  int errors = 0;
  int expv = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  peak_level_flag i_peak_level_flag (
    .clk(clk), .pd_n(pd_n), .pm_en(pm_en), .smp_valid(smp_valid),
    .smp_ready(smp_ready), .smp_data(smp_data), .rd_strobe(rd_strobe),
    .level_code(level_code)
  );

  function automatic int code_of(input int x);
    int m;
    m = (x < 0) ? ((x == -32768) ? 32767 : -x) : x;
    if (m >= 32767) return 6;
    if (m >= 26624) return 5;
    if (m >= 20480) return 4;
    if (m >= 16384) return 3;
    if (m >= 12288) return 2;
    if (m >= 8192)  return 1;
    return 0;
  endfunction

  task automatic check(input string req, input int act, input int exp_val);
    checks++;
    if (act != exp_val) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp_val);
    end
  endtask

  task automatic cyc(input bit v, input int d, input bit r, input bit p, input string req);
    int e;
    @(negedge clk);
    smp_valid = v; smp_data = 16'(d); rd_strobe = r; pm_en = p;
    if (!p) expv = 0;
    else if (v) begin
      e = code_of(d);
      expv = r ? e : ((e > expv) ? e : expv);
    end else if (r) expv = 0;
    @(posedge clk);
    #2;
    check(req, int'(level_code), expv);
    if (level_code == 3'b111) check("R8", int'(level_code), expv);
  endtask

  int edges[6] = '{8192, 12288, 16384, 20480, 26624, 32767};

  initial begin
    void'($urandom(32'd7717));
    #25;
    check("R1", int'(level_code), 0);
    check("R9", int'(smp_ready), 1);
    pd_n = 1'b1;
    @(negedge clk);
    check("R1", int'(level_code), 0);

    // band edges, each loaded under a read (R2, R6)
    for (int k = 0; k < 6; k++) begin
      cyc(1, edges[k] - 1, 1, 1, "R2");
      cyc(1, edges[k], 1, 1, "R2");
    end
    // negative magnitudes (R3)
    cyc(1, -8192, 1, 1, "R3");
    cyc(1, -8191, 1, 1, "R3");
    cyc(1, -32767, 1, 1, "R3");
    cyc(1, -32768, 1, 1, "R3");
    // hold the maximum (R4)
    cyc(0, 0, 1, 1, "R5");
    cyc(1, 20480, 0, 1, "R4");
    cyc(1, 9000, 0, 1, "R4");
    cyc(1, -13000, 0, 1, "R4");
    // data with valid low ignored (R9)
    cyc(0, 32767, 0, 1, "R9");
    check("R9", int'(smp_ready), 1);
    // read clears (R5)
    cyc(0, 0, 1, 1, "R5");
    // read together with a lower sample after a high peak (R6)
    cyc(1, 30000, 0, 1, "R4");
    cyc(1, 8500, 1, 1, "R6");
    cyc(1, 100, 1, 1, "R6");
    // power management off (R7)
    cyc(1, 30000, 0, 1, "R4");
    cyc(1, 32767, 0, 0, "R7");
    cyc(1, -32768, 0, 0, "R7");
    cyc(0, 0, 0, 1, "R7");
    // power-down mid-run (R1)
    cyc(1, 27000, 0, 1, "R4");
    @(negedge clk);
    smp_valid = 1'b0; rd_strobe = 1'b0;
    pd_n = 1'b0;
    #3;
    check("R1", int'(level_code), 0);
    @(negedge clk);
    pd_n = 1'b1;
    expv = 0;
    @(negedge clk);
    check("R1", int'(level_code), 0);

    // random phase, biased toward band edges (R2, R4, R6, R8)
    for (int i = 0; i < 4000; i++) begin
      int d;
      bit v, r, p;
      if ($urandom_range(1, 0) == 0) d = int'($signed(16'($urandom())));
      else begin
        d = edges[$urandom_range(5, 0)] - int'($urandom_range(1, 0));
        if ($urandom_range(1, 0) == 1) d = -d;
        if (d == -32767 && $urandom_range(1, 0) == 1) d = -32768;
      end
      v = ($urandom_range(3, 0) != 0);
      r = ($urandom_range(7, 0) == 0);
      p = ($urandom_range(31, 0) != 0);
      cyc(v, d, r, p, "R4");
    end
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule